// File: doc/BRIEF.md
# Power-of-Two Pad Input Debouncer

This block cleans up one slow pad input before the logic behind it uses it. The raw pad level first passes through a synchronizer. It can then pass through an optional short glitch stage. After that comes a debounce window. The window length is a power of two multiple of a fixed base tick of 31.25 us. A built-in prescaler derives that tick from the clock frequency. The debounced level is presented on a registered output, together with a one-cycle strobe each time that level toggles.

Software-side logic supplies a 5-bit configuration word and a glitch-select bit, and captures both with a load strobe. The word holds the enable and the window exponent. Capturing a configuration also restarts the timing and snaps the output to the current synchronized pad level. With debouncing off, or with an illegal exponent, the block is a plain synchronizer with one output register.

Top module: `pad_debounce_top`

## Requirements
- R1: During and right after synchronous reset, `pad_out` is 0 and `pad_chg` is 0, and the captured configuration is "disabled".
- R2: Configuration word bit 0 is the debounce enable. With it at 0, `pad_out` equals the value `pad_in` had three clock edges earlier: two synchronizer stages plus the output register.
- R3: Bits 4:1 of the configuration word hold the exponent N. Values 0, 1 and 2 are illegal and behave exactly like R2 even with the enable set. In that case the glitch-select bit has no effect.
- R4: With enable set and N between 3 and 15, a level change held at `pad_in` reaches `pad_out` only after 2^N base ticks of disagreement. Let T be the tick period in clocks. Measured in clock edges from the edge that first samples the new level, the output is still old after 1+(2^N-1)·T edges and is new after 2+2^N·T edges.
- R5: With debouncing active, a pad pulse lasting (2^N-1)·T-1 clocks or less never reaches `pad_out` and produces no strobe.
- R6: With debouncing active and the glitch-select bit set, the new level must first persist for 2 ticks before the window starts. The output is still old after 2+2^N·T edges and is new after 2+(2^N+2)·T edges.
- R7: With the glitch stage active, a pad pulse shorter than one tick period is removed and produces no strobe.
- R8: A configuration load clears the window and glitch counters and the prescaler. On that same edge it loads `pad_out` from the synchronized pad level, even when the window has not elapsed.
- R9: `pad_chg` is high for exactly the cycle in which `pad_out` holds a value different from the cycle before, and is low otherwise.
- R10: The tick period T is the parameter `TICK_CYCLES`. By default this is the clock frequency divided by 32000, which gives 31.25 us.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | 1 | Raw, asynchronous pad level |
| cfg_load | input | 1 | Captures `cfg_word` and `glitch_sel` on this edge |
| cfg_word | input | 5 | Bit 0 enable, bits 4:1 exponent N |
| glitch_sel | input | 1 | Inserts the 2-tick glitch stage when debouncing is active |
| pad_out | output | 1 | Debounced level (registered) |
| pad_chg | output | 1 | One-cycle strobe on each toggle of `pad_out` |

## Verification
The bench builds the block with `TICK_CYCLES` = 4, so that windows of 8 to 64 ticks take only tens to a few hundred clocks. The bench sweeps every exponent from 3 to 6 in both edge directions, with and without the glitch stage. It also sweeps all three illegal exponents and the disabled case. A small tick count makes the bounds of R4 and R6 a few clocks wide. The checks can then tell whether the glitch stage really delays the output, whether a one-tick-short pulse is really rejected, and whether a load with N=15 snaps the output long before its second-long window.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  localparam int unsigned BASE_TICK_HZ = 32_000;
  localparam int unsigned EXP_W        = 4;
  localparam int unsigned EXP_MIN      = 3;
  localparam int unsigned EXP_MAX      = (1 << EXP_W) - 1;
  localparam int unsigned WIN_CNT_W    = EXP_MAX + 1;

  typedef struct packed {
    logic [EXP_W-1:0] expo;
    logic             en;
  } dbc_cfg_t;

  function automatic logic cfg_active(input dbc_cfg_t c);
    return c.en && (c.expo >= EXP_W'(EXP_MIN));
  endfunction

endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdb_prescale.sv
module pdb_prescale #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || restart)  pcnt <= '0;
    else if (pcnt == LAST) pcnt <= '0;
    else                 pcnt <= pcnt + W'(1);
  end

  assign tick = (pcnt == LAST);

  // R10: the divider never leaves its range
  p_range_r10: assert property (@(posedge clk) disable iff (rst)
    pcnt <= LAST);
endmodule

// File: rtl/pdb_glitch.sv
module pdb_glitch #(
  parameter int unsigned TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic active,
  input  logic tick,
  input  logic d,
  output logic q
);
  localparam int unsigned W = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= 1'b0;
      gcnt <= '0;
    end else if (load || !active) begin
      q    <= d;
      gcnt <= '0;
    end else if (d == q) begin
      gcnt <= '0;
    end else if (tick) begin
      if (gcnt == LAST) begin
        q    <= d;
        gcnt <= '0;
      end else begin
        gcnt <= gcnt + W'(1);
      end
    end
  end

  // R7: while filtering, the filtered level only moves on a tick
  p_move_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(active) && !$past(load) && q != $past(q))
      |-> $past(tick));
endmodule

// File: rtl/pdb_window.sv
module pdb_window
  import pdb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             en,
  input  logic [EXP_W-1:0] expo,
  input  logic             tick,
  input  logic             d,
  input  logic             s,
  output logic             out,
  output logic             chg
);
  logic [WIN_CNT_W-1:0] wcnt;
  logic [WIN_CNT_W-1:0] limit_m1;

  assign limit_m1 = (WIN_CNT_W'(1) << expo) - WIN_CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out  <= 1'b0;
      chg  <= 1'b0;
      wcnt <= '0;
    end else begin
      chg <= 1'b0;
      if (load || !en) begin
        out  <= s;
        chg  <= (s != out);
        wcnt <= '0;
      end else if (d == out) begin
        wcnt <= '0;
      end else if (tick) begin
        if (wcnt == limit_m1) begin
          out  <= d;
          chg  <= 1'b1;
          wcnt <= '0;
        end else begin
          wcnt <= wcnt + WIN_CNT_W'(1);
        end
      end
    end
  end

  // R2, R3: without an active window the output tracks the synchronized level
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> out == $past(s));

  // R9: strobe marks exactly the cycles where the output differs from before
  p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> chg == (out != $past(out)));

  // R4: an enabled output change happens on a tick, toward the filtered level
  p_settle_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && !$past(load) && out != $past(out))
      |-> ($past(tick) && $past(d) == out));

  // R4: the tick counter never passes the window length
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> wcnt <= limit_m1);
endmodule

// File: rtl/pad_debounce_top.sv
module pad_debounce_top
  import pdb_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 32_000_000,
  parameter int unsigned TICK_CYCLES  = CLK_HZ / BASE_TICK_HZ,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned GLITCH_TICKS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pad_in,
  input  logic           cfg_load,
  input  logic [EXP_W:0] cfg_word,
  input  logic           glitch_sel,
  output logic           pad_out,
  output logic           pad_chg
);
  dbc_cfg_t cfg_q;
  logic     glt_q;
  logic     dbc_on;
  logic     glt_on;
  logic     s_lvl;
  logic     g_lvl;
  logic     f_lvl;
  logic     tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      glt_q <= 1'b0;
    end else if (cfg_load) begin
      cfg_q <= dbc_cfg_t'(cfg_word);
      glt_q <= glitch_sel;
    end
  end

  assign dbc_on = cfg_active(cfg_q);
  assign glt_on = dbc_on && glt_q;

  pdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (s_lvl)
  );

  pdb_prescale #(.DIV(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (cfg_load),
    .tick    (tick)
  );

  pdb_glitch #(.TICKS(GLITCH_TICKS)) u_glitch (
    .clk    (clk),
    .rst    (rst),
    .load   (cfg_load),
    .active (glt_on),
    .tick   (tick),
    .d      (s_lvl),
    .q      (g_lvl)
  );

  assign f_lvl = glt_on ? g_lvl : s_lvl;

  pdb_window u_win (
    .clk  (clk),
    .rst  (rst),
    .load (cfg_load),
    .en   (dbc_on),
    .expo (cfg_q.expo),
    .tick (tick),
    .d    (f_lvl),
    .s    (s_lvl),
    .out  (pad_out),
    .chg  (pad_chg)
  );

  // R8: a load snaps the output to the synchronized level
  p_load_snap_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_load)) |-> pad_out == $past(s_lvl));

  // R1: reset leaves the output low and quiet
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!pad_out && !pad_chg));
endmodule

// File: tb/test_pad_debounce_top.sv
module test_pad_debounce_top;
  localparam int CLK_P = 10;
  localparam int T     = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pad_in = 1'b0;
  logic       cfg_load = 1'b0;
  logic [4:0] cfg_word = '0;
  logic       glitch_sel = 1'b0;
  logic       pad_out;
  logic       pad_chg;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  chg_cnt = 0;
  logic lvl = 1'b0;

  pad_debounce_top #(.CLK_HZ(128_000), .TICK_CYCLES(T)) i_pad_debounce_top (
    .clk        (clk),
    .rst        (rst),
    .pad_in     (pad_in),
    .cfg_load   (cfg_load),
    .cfg_word   (cfg_word),
    .glitch_sel (glitch_sel),
    .pad_out    (pad_out),
    .pad_chg    (pad_chg)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (!rst && pad_chg) chg_cnt <= chg_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_cfg(input bit en, input int n, input bit g);
    cfg_word   = {n[3:0], en};
    glitch_sel = g;
    cfg_load   = 1'b1;
    cyc(1);
    cfg_load   = 1'b0;
  endtask

  // R2 / R3: bypass latency of exactly three edges
  task automatic bypass_case(input bit en, input int n, input bit g, input string req);
    load_cfg(en, n, g);
    cyc(4);
    pad_in = ~lvl;
    cyc(2);
    chk(pad_out == lvl, req, pad_out, lvl);
    cyc(1);
    chk(pad_out == ~lvl && pad_chg, req, {pad_out, pad_chg}, {~lvl, 1'b1});
    cyc(1);
    chk(!pad_chg, "R9", pad_chg, 0);
    lvl = ~lvl;
  endtask

  // R4 / R6: edge through the window, with bounds from the tick count
  task automatic edge_case(input int n, input bit g);
    int c0;
    int w;
    w = (1 << n) * T;
    load_cfg(1'b1, n, g);
    cyc(8);
    c0 = chg_cnt;
    pad_in = ~lvl;
    if (!g) begin
      cyc(2 + w - T);
      chk(pad_out == lvl, "R4 early", pad_out, lvl);
      cyc(T);
      chk(pad_out == ~lvl, "R4 late", pad_out, ~lvl);
    end else begin
      cyc(2 + w);
      chk(pad_out == lvl, "R6 early", pad_out, lvl);
      cyc(2 * T);
      chk(pad_out == ~lvl, "R6 late", pad_out, ~lvl);
    end
    cyc(2);
    chk(chg_cnt == c0 + 1, "R9 count", chg_cnt - c0, 1);
    lvl = ~lvl;
  endtask

  initial begin
    cyc(3);
    chk(!pad_out && !pad_chg, "R1", {pad_out, pad_chg}, 0);
    rst = 1'b0;
    cyc(1);
    chk(!pad_out && !pad_chg, "R1", {pad_out, pad_chg}, 0);

    // R2: disabled, R3: illegal exponents with glitch select ignored
    bypass_case(1'b0, 5, 1'b0, "R2");
    bypass_case(1'b0, 9, 1'b1, "R2");
    for (int n = 0; n < 3; n++) begin
      bypass_case(1'b1, n, 1'b1, "R3");
      bypass_case(1'b1, n, 1'b0, "R3");
    end

    // R4 / R6 sweep, both directions
    for (int n = 3; n <= 6; n++) begin
      for (int g = 0; g < 2; g++) begin
        edge_case(n, g[0]);
        edge_case(n, g[0]);
      end
    end

    // R5: pulse one tick too short for the window
    for (int n = 3; n <= 5; n++) begin
      int c0;
      load_cfg(1'b1, n, 1'b0);
      cyc(4);
      c0 = chg_cnt;
      pad_in = ~lvl;
      cyc((1 << n) * T - T - 1);
      pad_in = lvl;
      cyc((1 << n) * T * 2);
      chk(pad_out == lvl && chg_cnt == c0, "R5", chg_cnt - c0, 0);
    end

    // R7: sub-tick glitch removed by the glitch stage
    begin
      int c0;
      load_cfg(1'b1, 3, 1'b1);
      cyc(4);
      c0 = chg_cnt;
      for (int k = 0; k < 5; k++) begin
        pad_in = ~lvl;
        cyc(T - 1);
        pad_in = lvl;
        cyc(3 * T);
      end
      cyc(100);
      chk(pad_out == lvl && chg_cnt == c0, "R7", chg_cnt - c0, 0);
    end

    // R8: load snaps output during a long window
    load_cfg(1'b1, 15, 1'b0);
    cyc(4);
    pad_in = ~lvl;
    cyc(60);
    chk(pad_out == lvl, "R8 hold", pad_out, lvl);
    load_cfg(1'b1, 15, 1'b0);
    chk(pad_out == ~lvl && pad_chg, "R8 snap", {pad_out, pad_chg}, {~lvl, 1'b1});
    cyc(1);
    chk(!pad_chg, "R9", pad_chg, 0);
    lvl = ~lvl;

    // R8: counter cleared by load, full window needed afterwards
    load_cfg(1'b1, 3, 1'b0);
    cyc(4);
    pad_in = ~lvl;
    cyc(20);
    load_cfg(1'b1, 3, 1'b0);
    chk(pad_out == ~lvl, "R8 snap2", pad_out, ~lvl);
    lvl = ~lvl;
    pad_in = ~lvl;
    cyc(2 + 8 * T - T);
    chk(pad_out == lvl, "R8 restart", pad_out, lvl);
    cyc(T);
    chk(pad_out == ~lvl, "R4 after load", pad_out, ~lvl);
    lvl = ~lvl;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule